// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block is the interrupt logic of one channel of an 8250-style serial port. It watches four interrupt conditions: receiver line status, received data available, transmitter holding register empty and modem status. Each condition passes through its own bit of a 4-bit enable value. Of the conditions that are both pending and enabled, the one with the highest priority is reported as a 3-bit identification code, and a single interrupt request line is driven.

Three of the conditions arrive as one-cycle events and are held in sticky flags until the host does the access that clears them. These are line status, transmit empty and modem status. Line status clears on a line status register read, modem status on a modem status register read. Transmit empty clears on a write to the transmit holding register, or on an identification register read made while transmit empty is the reported code. Received data available is a level from the receive FIFO: it is asserted while the fill level is at or above the trigger. Both outputs are registered. The flags keep their state while masked, so enabling a source later shows an interrupt that is already pending.

Top module: `uart_irq_prio`

## Requirements
- R1: While reset is applied and in the first cycle after it, `irq` is 0, `iir_id` is 001 and all sticky flags are clear.
- R2: Enable bit positions are: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem. A source whose enable bit is 0 never raises `irq` and is never reported.
- R3: Priority from highest to lowest is line status, received data, transmit empty, modem. The codes are 110, 100, 010 and 000 respectively. Code 001 means nothing is pending.
- R4: `iir_id[0]` is 0 exactly when `irq` is 1.
- R5: A `ls_evt` pulse sets the line status flag. It stays set until a cycle with `lsr_rd` high.
- R6: The received data source follows `rx_lvl` directly and has no memory.
- R7: The transmit empty flag is set by `tx_evt`. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where `iir_id` currently reads 010. An `iir_rd` while any other code is shown leaves the flag set.
- R8: A `ms_evt` pulse sets the modem flag. It stays set until a cycle with `msr_rd` high.
- R9: When a set event and a clear action for the same flag occur in the same cycle, the flag ends up set.
- R10: `irq` and `iir_id` are registered. After each clock edge they reflect the inputs sampled at that edge.
- R11: A flag set while its source is masked is kept. Setting the enable bit afterwards reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier | input | 4 | Per-source enable: 0 rx data, 1 tx empty, 2 line status, 3 modem |
| ls_evt | input | 1 | One-cycle pulse: line error detected |
| lsr_rd | input | 1 | Host reads line status register |
| rx_lvl | input | 1 | Receive FIFO at or above trigger level |
| tx_evt | input | 1 | One-cycle pulse: transmit holding register became empty |
| thr_wr | input | 1 | Host writes transmit holding register |
| iir_rd | input | 1 | Host reads identification register |
| ms_evt | input | 1 | One-cycle pulse: modem line change |
| msr_rd | input | 1 | Host reads modem status register |
| irq | output | 1 | Interrupt request, registered |
| iir_id | output | 3 | Identification code, registered |

## Verification
Raising a source and clearing it can fall in the same cycle. Examples are a transmit-empty event together with a holding register write, and a line error together with a line status read. In both cases the flag must end up set. The bench drives these pairs in a single cycle and also sweeps random mixes of events and host accesses. A behavioural model settles each collision in favour of the set, and the identification code is compared one edge later. A second collision is an identification read that lands while transmit empty is shown at the moment a higher source arrives. The model decides the clear from the code that was visible when the read was made.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 4;
  localparam int ID_W = 3;

  // enable / source bit positions
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LS = 2;
  localparam int SRC_MS = 3;

  typedef enum logic [ID_W-1:0] {
    ID_NONE    = 3'b001,
    ID_LINE    = 3'b110,
    ID_RXDATA  = 3'b100,
    ID_TXEMPTY = 3'b010,
    ID_MODEM   = 3'b000
  } irq_id_e;

  // fixed priority: line status > rx data > tx empty > modem
  function automatic logic [ID_W-1:0] encode_id(input logic [NSRC-1:0] act);
    logic [ID_W-1:0] r;
    if (act[SRC_LS])      r = ID_LINE;
    else if (act[SRC_RX]) r = ID_RXDATA;
    else if (act[SRC_TX]) r = ID_TXEMPTY;
    else if (act[SRC_MS]) r = ID_MODEM;
    else                  r = ID_NONE;
    return r;
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic d
);
  // set wins over clear in the same cycle
  assign d = set | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] act,
  output logic [ID_W-1:0] id,
  output logic            any
);
  assign act = pend & mask;
  assign any = |act;
  assign id  = encode_id(act);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ier,
  input  logic            ls_evt,
  input  logic            lsr_rd,
  input  logic            rx_lvl,
  input  logic            tx_evt,
  input  logic            thr_wr,
  input  logic            iir_rd,
  input  logic            ms_evt,
  input  logic            msr_rd,
  output logic            irq,
  output logic [ID_W-1:0] iir_id
);
  // named internal events
  logic            tx_clr_by_id;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_nx;
  logic [NSRC-1:0] act_nx;
  logic [ID_W-1:0] id_nx;
  logic            any_nx;

  assign tx_clr_by_id = iir_rd && (iir_id == ID_TXEMPTY);

  always_comb begin
    set_vec         = '0;
    clr_vec         = '0;
    set_vec[SRC_RX] = rx_lvl;
    clr_vec[SRC_RX] = ~rx_lvl;
    set_vec[SRC_TX] = tx_evt;
    clr_vec[SRC_TX] = thr_wr | tx_clr_by_id;
    set_vec[SRC_LS] = ls_evt;
    clr_vec[SRC_LS] = lsr_rd;
    set_vec[SRC_MS] = ms_evt;
    clr_vec[SRC_MS] = msr_rd;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == SRC_RX) begin : g_level
      assign pend_nx[g] = set_vec[g] & ~clr_vec[g];
      assign pend_q[g]  = 1'b0;
    end else begin : g_sticky
      uart_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_vec[g]),
        .clr  (clr_vec[g]),
        .q    (pend_q[g]),
        .d    (pend_nx[g])
      );
    end
  end

  uart_irq_enc u_enc (
    .pend(pend_nx),
    .mask(ier),
    .act (act_nx),
    .id  (id_nx),
    .any (any_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      iir_id <= ID_NONE;
    end else begin
      irq    <= any_nx;
      iir_id <= id_nx;
    end
  end
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ier,
  input logic            ls_evt,
  input logic            tx_evt,
  input logic            thr_wr,
  input logic            rx_lvl,
  input logic            irq,
  input logic [ID_W-1:0] iir_id
);
  p_irq_vs_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iir_id[0]);

  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iir_id inside {3'b001, 3'b110, 3'b100, 3'b010, 3'b000});

  p_mask_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |=> !irq);

  p_line_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_evt && ier[SRC_LS]) |=> (iir_id == 3'b110));

  p_rx_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl && ier[SRC_RX]) |=> irq);

  p_thr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_evt) |=> (iir_id != 3'b010));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && thr_wr && ier[SRC_TX] && !ier[SRC_LS] && !ier[SRC_RX])
      |=> (iir_id == 3'b010));
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ier   (ier),
  .ls_evt(ls_evt),
  .tx_evt(tx_evt),
  .thr_wr(thr_wr),
  .rx_lvl(rx_lvl),
  .irq   (irq),
  .iir_id(iir_id)
);

// File: tb/uart_irq_prio_tb.sv
`timescale 1ns/1ps
module uart_irq_prio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ier = 4'h0;
  logic ls_evt = 0, lsr_rd = 0, rx_lvl = 0, tx_evt = 0, thr_wr = 0;
  logic iir_rd = 0, ms_evt = 0, msr_rd = 0;
  logic       irq;
  logic [2:0] iir_id;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string tag = "R1";

  // behavioural reference state
  bit       m_ls, m_tx, m_ms;
  bit       e_irq;
  bit [2:0] e_id = 3'b001;

  always #2 clk = ~clk;

  uart_irq_prio u_dut (
    .clk(clk), .rst_n(rst_n), .ier(ier),
    .ls_evt(ls_evt), .lsr_rd(lsr_rd), .rx_lvl(rx_lvl),
    .tx_evt(tx_evt), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .ms_evt(ms_evt), .msr_rd(msr_rd),
    .irq(irq), .iir_id(iir_id)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ls = 0; m_tx = 0; m_ms = 0; e_irq = 0; e_id = 3'b001;
    end else begin
      bit tx_clear;
      bit a_ls, a_rx, a_tx, a_ms;
      tx_clear = thr_wr || (iir_rd && e_id == 3'b010);
      if (ls_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
      if (tx_evt) m_tx = 1; else if (tx_clear) m_tx = 0;
      if (ms_evt) m_ms = 1; else if (msr_rd) m_ms = 0;
      a_rx = rx_lvl && ier[0];
      a_tx = m_tx && ier[1];
      a_ls = m_ls && ier[2];
      a_ms = m_ms && ier[3];
      e_irq = a_ls || a_rx || a_tx || a_ms;
      if (a_ls) e_id = 3'b110;
      else if (a_rx) e_id = 3'b100;
      else if (a_tx) e_id = 3'b010;
      else if (a_ms) e_id = 3'b000;
      else e_id = 3'b001;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (irq !== e_irq || iir_id !== e_id) begin
        n_fail++;
        $display("FAIL %s cycle %0d: irq=%b id=%b expected irq=%b id=%b",
                 tag, cyc, irq, iir_id, e_irq, e_id);
      end
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet();
    ls_evt = 0; lsr_rd = 0; tx_evt = 0; thr_wr = 0;
    iir_rd = 0; ms_evt = 0; msr_rd = 0;
  endtask

  task automatic expect_out(input string t, input bit xi, input bit [2:0] xid);
    n_chk++;
    if (irq !== xi || iir_id !== xid) begin
      n_fail++;
      $display("FAIL %s: irq=%b id=%b expected irq=%b id=%b", t, irq, iir_id, xi, xid);
    end
  endtask

  initial begin
    // watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 0, 3'b001);
    rst_n = 1;
    step();
    expect_out("R1 after reset", 0, 3'b001);

    // R2: everything masked
    tag = "R2";
    ier = 4'h0; ls_evt = 1; tx_evt = 1; ms_evt = 1; rx_lvl = 1;
    step(); quiet();
    step();
    expect_out("R2 all masked", 0, 3'b001);

    // R11: enabling shows latched flags
    tag = "R11";
    ier = 4'hF;
    step();
    expect_out("R11 unmask shows line", 1, 3'b110);

    // R3: peel off by priority
    tag = "R3";
    lsr_rd = 1; step(); quiet();
    expect_out("R3 rx after line", 1, 3'b100);
    rx_lvl = 0; step();
    expect_out("R3 tx after rx", 1, 3'b010);
    thr_wr = 1; step(); quiet();
    expect_out("R3 modem last", 1, 3'b000);
    tag = "R8";
    msr_rd = 1; step(); quiet();
    expect_out("R8 modem cleared", 0, 3'b001);

    // R6: level follows, R10 one edge latency
    tag = "R6";
    rx_lvl = 1; step();
    expect_out("R6 R10 rx level", 1, 3'b100);
    rx_lvl = 0; step();
    expect_out("R6 rx gone", 0, 3'b001);

    // R7: id read clears tx only when reported
    tag = "R7";
    tx_evt = 1; step(); quiet();
    expect_out("R7 tx reported", 1, 3'b010);
    iir_rd = 1; step(); quiet();
    expect_out("R7 id read clears tx", 0, 3'b001);
    tx_evt = 1; ls_evt = 1; step(); quiet();
    expect_out("R7 line over tx", 1, 3'b110);
    iir_rd = 1; step(); quiet();
    expect_out("R7 id read while line shown", 1, 3'b110);
    lsr_rd = 1; step(); quiet();
    expect_out("R7 tx kept", 1, 3'b010);
    // read while tx shown, line arrives same cycle: tx still cleared
    iir_rd = 1; ls_evt = 1; step(); quiet();
    expect_out("R7 read with new line", 1, 3'b110);
    lsr_rd = 1; step(); quiet();
    expect_out("R7 tx gone", 0, 3'b001);

    // R5: line flag sticky
    tag = "R5";
    ls_evt = 1; step(); quiet();
    repeat (3) step();
    expect_out("R5 line held", 1, 3'b110);
    lsr_rd = 1; step(); quiet();
    expect_out("R5 line cleared", 0, 3'b001);

    // R9: set wins
    tag = "R9";
    tx_evt = 1; thr_wr = 1; step(); quiet();
    expect_out("R9 tx set wins", 1, 3'b010);
    thr_wr = 1; step(); quiet();
    ls_evt = 1; lsr_rd = 1; step(); quiet();
    expect_out("R9 line set wins", 1, 3'b110);
    lsr_rd = 1; step(); quiet();
    ms_evt = 1; msr_rd = 1; step(); quiet();
    expect_out("R9 modem set wins", 1, 3'b000);
    msr_rd = 1; step(); quiet();
    expect_out("R9 idle", 0, 3'b001);

    // R2: single mask bit hides only its source
    tag = "R2";
    ier = 4'b1011; ls_evt = 1; ms_evt = 1; step(); quiet();
    expect_out("R2 line masked", 1, 3'b000);
    ier = 4'hF; lsr_rd = 1; msr_rd = 1; step(); quiet();

    // random sweep against the model
    tag = "R3";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      ls_evt = (r[3:0] == 0);  lsr_rd = (r[7:4] < 2);
      tx_evt = (r[11:8] < 2);  thr_wr = (r[15:12] == 0);
      iir_rd = (r[19:16] < 3); ms_evt = (r[23:20] == 0);
      msr_rd = (r[27:24] < 2);
      if (r[31:28] == 0) rx_lvl = ~rx_lvl;
      if ((i % 97) == 0) ier = 4'($urandom);
      step();
    end
    quiet();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule